// File: doc/BRIEF.md
# Posted-Write Peripheral Bridge

This block joins a fast processor-side bus to a slower peripheral-side bus inside a single clock domain. A clock-enable strobe, `slow_en`, paces the peripheral side and stands in for a slower peripheral clock. A single write from the processor is accepted at once and parked in a one-entry buffer. The buffer then drains that write to the peripheral through a two-phase transfer: a setup cycle, then an access cycle.

Because of this, the processor can treat a write as finished while the peripheral register still holds its old value. The `write_pending` output shows when the processor's view and the peripheral's state differ. Software that clears an interrupt or status flag by a write must wait for `write_pending` to fall, or follow the write with a read, before it relies on the flag being clear.

Reads are never posted. A read waits until the buffered write has fully completed, then runs its own peripheral transfer. The read is answered in the access cycle of that transfer, so it always returns up-to-date data.

Top module: `posted_wr_bridge`

## Requirements
- R1: When `write_pending` is low, a write request (`m_req`=1, `m_we`=1) sees `m_ready` high in the same cycle and is accepted at that clock edge, whatever the state of `slow_en`.
- R2: `write_pending` goes high in the cycle after a write is accepted. It stays high through the peripheral access cycle of that write and is low in the cycle after that access cycle completes.
- R3: While `write_pending` is high, the target peripheral register keeps its old value. A status register cleared by a posted write reads as cleared only once `write_pending` has fallen.
- R4: Each peripheral transfer is one setup cycle (`p_sel`=1, `p_enable`=0) followed by one access cycle (`p_sel`=1, `p_enable`=1). The transfer completes on an access cycle in which `slow_en` is high.
- R5: The peripheral-side outputs and the transfer progress change only at clock edges where `slow_en` is high. While `slow_en` stays low, `p_sel`, `p_enable` and `write_pending` hold their values.
- R6: A write presented while `write_pending` is high sees `m_ready` low until the buffer drains. Once the buffer drains, that write is accepted, and neither write is lost.
- R7: A read (`m_req`=1, `m_we`=0) is answered only when no write is pending. It is answered in the cycle of its own peripheral access cycle, with `m_ready` high and `m_rdata` equal to `p_rdata`, so a read after a write returns the written data.
- R8: Byte strobes are carried unchanged to `p_strb`, with bit i covering data bits 8i+7..8i. Only the enabled byte lanes of the peripheral register change.
- R9: During and right after reset, `p_sel`, `p_enable` and `write_pending` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor-side clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_en | input | 1 | Peripheral-side advance strobe |
| m_req | input | 1 | Master request, held until `m_ready` |
| m_we | input | 1 | 1 = write, 0 = read |
| m_addr | input | AW | Byte address |
| m_wdata | input | DW | Write data |
| m_be | input | DW/8 | Byte enables |
| m_ready | output | 1 | Transfer accepted (write) or answered (read) |
| m_rdata | output | DW | Read data, valid when a read sees `m_ready` |
| write_pending | output | 1 | A posted write has not yet reached the peripheral |
| p_sel | output | 1 | Peripheral select |
| p_enable | output | 1 | Peripheral access phase |
| p_write | output | 1 | Peripheral transfer direction |
| p_addr | output | AW | Peripheral address |
| p_wdata | output | DW | Peripheral write data |
| p_strb | output | DW/8 | Peripheral byte strobes |
| p_rdata | input | DW | Peripheral read data |

## Verification
The bench runs the bridge with three `slow_en` patterns: a random sparse enable, an enable held low, and an enable held high. The random pattern tests posting and draining under uneven peripheral speed. The held-low pattern separates a design that advances only on the strobe from one that advances on every clock. The held-high pattern pins down the exact setup and access cycles. Directed sequences cover a status clear followed by a read, a write immediately after a write (to show the stall), a read immediately after a write (to show read ordering), and partial byte strobes. A random mix of reads and writes then compares every read against a model of the peripheral registers as seen by software.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    typedef enum logic [1:0] {
        PS_IDLE   = 2'd0,
        PS_SETUP  = 2'd1,
        PS_ACCESS = 2'd2
    } pside_state_e;
endpackage

// File: rtl/pwb_slot.sv
module pwb_slot #(
    parameter int AW = 12,
    parameter int DW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [AW-1:0]        ld_addr,
    input  logic [DW-1:0]        ld_data,
    input  logic [DW/8-1:0]      ld_strb,
    input  logic                 drain,
    output logic                 valid,
    output logic [AW-1:0]        addr,
    output logic [DW-1:0]        data,
    output logic [DW/8-1:0]      strb
);
    localparam int SW = DW / 8;

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [SW-1:0] strb;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (drain) begin
            slot_d.valid = 1'b0;
        end
        if (load) begin
            slot_d.valid = 1'b1;
            slot_d.addr  = ld_addr;
            slot_d.data  = ld_data;
            slot_d.strb  = ld_strb;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign valid = slot_q.valid;
    assign addr  = slot_q.addr;
    assign data  = slot_q.data;
    assign strb  = slot_q.strb;

    // R6: an occupied entry is never overwritten by a new load
    a_r6_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.valid && !drain) |-> !load);
endmodule

// File: rtl/pwb_pside.sv
module pwb_pside
    import pwb_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 slow_en,
    input  logic                 start,
    input  logic                 st_write,
    input  logic [AW-1:0]        st_addr,
    input  logic [DW-1:0]        st_data,
    input  logic [DW/8-1:0]      st_strb,
    output logic                 done,
    output logic                 p_sel,
    output logic                 p_enable,
    output logic                 p_write,
    output logic [AW-1:0]        p_addr,
    output logic [DW-1:0]        p_wdata,
    output logic [DW/8-1:0]      p_strb
);
    localparam int SW = DW / 8;

    typedef struct packed {
        pside_state_e  st;
        logic          write;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [SW-1:0] strb;
    } xfer_t;

    xfer_t xf_d, xf_q;

    always_comb begin
        xf_d = xf_q;
        if (slow_en) begin
            unique case (xf_q.st)
                PS_IDLE: begin
                    if (start) begin
                        xf_d.st    = PS_SETUP;
                        xf_d.write = st_write;
                        xf_d.addr  = st_addr;
                        xf_d.data  = st_data;
                        xf_d.strb  = st_strb;
                    end
                end
                PS_SETUP:  xf_d.st = PS_ACCESS;
                PS_ACCESS: xf_d.st = PS_IDLE;
                default:   xf_d.st = PS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xf_q <= '{st: PS_IDLE, default: '0};
        end else begin
            xf_q <= xf_d;
        end
    end

    assign done     = (xf_q.st == PS_ACCESS) && slow_en;
    assign p_sel    = (xf_q.st != PS_IDLE);
    assign p_enable = (xf_q.st == PS_ACCESS);
    assign p_write  = xf_q.write;
    assign p_addr   = xf_q.addr;
    assign p_wdata  = xf_q.data;
    assign p_strb   = xf_q.strb;

    // R4: the access phase is entered only from a setup phase
    a_r4_access_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(p_enable) |-> $past(p_sel && !p_enable));

    // R5: peripheral outputs are frozen across a clock with slow_en low
    a_r5_hold_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !slow_en |=> ($stable(p_sel) && $stable(p_enable) && $stable(p_addr)));
endmodule

// File: rtl/posted_wr_bridge.sv
module posted_wr_bridge #(
    parameter int AW = 12,
    parameter int DW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 slow_en,
    input  logic                 m_req,
    input  logic                 m_we,
    input  logic [AW-1:0]        m_addr,
    input  logic [DW-1:0]        m_wdata,
    input  logic [DW/8-1:0]      m_be,
    output logic                 m_ready,
    output logic [DW-1:0]        m_rdata,
    output logic                 write_pending,
    output logic                 p_sel,
    output logic                 p_enable,
    output logic                 p_write,
    output logic [AW-1:0]        p_addr,
    output logic [DW-1:0]        p_wdata,
    output logic [DW/8-1:0]      p_strb,
    input  logic [DW-1:0]        p_rdata
);
    localparam int SW = DW / 8;

    logic          slot_valid, slot_load, slot_drain;
    logic [AW-1:0] slot_addr;
    logic [DW-1:0] slot_data;
    logic [SW-1:0] slot_strb;
    logic          xf_start, xf_write, xf_done;
    logic [AW-1:0] xf_addr;
    logic [DW-1:0] xf_data;
    logic [SW-1:0] xf_strb;

    always_comb begin
        slot_load = m_req && m_we && !slot_valid;
        xf_start  = slot_valid || (m_req && !m_we);
        xf_write  = slot_valid;
        xf_addr   = slot_valid ? slot_addr : m_addr;
        xf_data   = slot_valid ? slot_data : m_wdata;
        xf_strb   = slot_valid ? slot_strb : '0;
        slot_drain = xf_done && p_write;
        m_ready   = m_we ? !slot_valid : (xf_done && !p_write);
    end

    pwb_slot #(.AW(AW), .DW(DW)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (slot_load),
        .ld_addr (m_addr),
        .ld_data (m_wdata),
        .ld_strb (m_be),
        .drain   (slot_drain),
        .valid   (slot_valid),
        .addr    (slot_addr),
        .data    (slot_data),
        .strb    (slot_strb)
    );

    pwb_pside #(.AW(AW), .DW(DW)) u_pside (
        .clk      (clk),
        .rst_n    (rst_n),
        .slow_en  (slow_en),
        .start    (xf_start),
        .st_write (xf_write),
        .st_addr  (xf_addr),
        .st_data  (xf_data),
        .st_strb  (xf_strb),
        .done     (xf_done),
        .p_sel    (p_sel),
        .p_enable (p_enable),
        .p_write  (p_write),
        .p_addr   (p_addr),
        .p_wdata  (p_wdata),
        .p_strb   (p_strb)
    );

    assign write_pending = slot_valid;
    assign m_rdata       = p_rdata;

    // R2: pending holds until a peripheral write access completes
    a_r2_pending_held: assert property (@(posedge clk) disable iff (!rst_n)
        (write_pending && !(p_sel && p_enable && p_write && slow_en)) |=> write_pending);

    // R7: a read is answered only when no posted write remains
    a_r7_read_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_we && m_ready) |-> !write_pending);

    // R7: a read is answered in its own access cycle
    a_r7_read_in_access: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_we && m_ready) |-> (p_sel && p_enable && !p_write));
endmodule

// File: tb/sim_posted_wr_bridge.sv
module sim_posted_wr_bridge;
    localparam int AW = 12;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slow_en = 1'b0;
    logic m_req = 1'b0, m_we = 1'b0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_wdata = '0;
    logic [3:0] m_be = '0;
    logic m_ready, write_pending, p_sel, p_enable, p_write;
    logic [DW-1:0] m_rdata, p_wdata, p_rdata;
    logic [AW-1:0] p_addr;
    logic [3:0] p_strb;

    int checks = 0;
    int errors = 0;
    int mode = 0;
    logic [31:0] mem [16];
    logic [31:0] shadow [16];

    always #2 clk = ~clk;

    posted_wr_bridge #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .slow_en(slow_en),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_be(m_be),
        .m_ready(m_ready), .m_rdata(m_rdata), .write_pending(write_pending),
        .p_sel(p_sel), .p_enable(p_enable), .p_write(p_write), .p_addr(p_addr),
        .p_wdata(p_wdata), .p_strb(p_strb), .p_rdata(p_rdata)
    );

    // peripheral model: register file written in its access cycle
    assign p_rdata = mem[p_addr[5:2]];
    always @(posedge clk) begin
        if (p_sel && p_enable && p_write && slow_en) begin
            for (int b = 0; b < 4; b++)
                if (p_strb[b]) mem[p_addr[5:2]][8*b +: 8] <= p_wdata[8*b +: 8];
        end
    end

    // slow_en pattern: 0 random sparse, 1 held low, 2 held high
    always @(posedge clk) begin
        #1;
        case (mode)
            1: slow_en = 1'b0;
            2: slow_en = 1'b1;
            default: slow_en = (($urandom % 3) == 0);
        endcase
    end

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                          input logic [3:0] be);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = d[8*b +: 8];
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be,
                      output int stalls);
        @(negedge clk);
        m_req = 1'b1; m_we = 1'b1; m_addr = a; m_wdata = d; m_be = be;
        #1;
        stalls = 0;
        while (!m_ready) begin
            @(negedge clk); #1;
            stalls++;
        end
        @(posedge clk);
        shadow[a[5:2]] = merge(shadow[a[5:2]], d, be);
        #1;
        m_req = 1'b0; m_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d, output int stalls);
        @(negedge clk);
        m_req = 1'b1; m_we = 1'b0; m_addr = a;
        #1;
        stalls = 0;
        while (!m_ready) begin
            @(negedge clk); #1;
            stalls++;
        end
        d = m_rdata;
        @(posedge clk); #1;
        m_req = 1'b0;
    endtask

    task automatic wait_drain();
        @(negedge clk);
        while (write_pending) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int st, st2;
        logic [31:0] d;
        logic snap_sel, snap_en, snap_pend;
        logic [31:0] snap_mem;
        void'($urandom(32'd1234));
        for (int i = 0; i < 16; i++) begin
            mem[i] = 32'h0101_0101 * i;
            shadow[i] = mem[i];
        end
        mem[0] = 32'hFFFF_FFFF;
        shadow[0] = 32'hFFFF_FFFF;

        repeat (4) @(negedge clk);
        // R9: reset state
        chk("R9 pending", {31'b0, write_pending}, 32'd0);
        chk("R9 p_sel", {31'b0, p_sel}, 32'd0);
        chk("R9 p_enable", {31'b0, p_enable}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 pending after reset", {31'b0, write_pending}, 32'd0);

        // status register cleared by a posted write
        mode = 0;
        wr(12'h000, 32'h0, 4'hF, st);
        chk("R1 immediate accept", st, 0);
        chk("R2 pending after accept", {31'b0, write_pending}, 32'd1);
        chk("R3 status still set", mem[0], 32'hFFFF_FFFF);
        wait_drain();
        chk("R3 status cleared after drain", mem[0], 32'h0);
        rd(12'h000, d, st);
        chk("R3 R7 status reads cleared", d, 32'h0);

        // read straight after a posted write
        wr(12'h004, 32'hA5A5_5A5A, 4'hF, st);
        rd(12'h004, d, st);
        chk("R7 read waited", {31'b0, (st > 0)}, 32'd1);
        chk("R7 read after write", d, 32'hA5A5_5A5A);

        // back-to-back writes
        wr(12'h008, 32'h1111_2222, 4'hF, st);
        wr(12'h00C, 32'h3333_4444, 4'hF, st2);
        chk("R6 second write stalled", {31'b0, (st2 > 0)}, 32'd1);
        wait_drain();
        chk("R6 first write kept", mem[2], 32'h1111_2222);
        chk("R6 second write kept", mem[3], 32'h3333_4444);

        // slow_en held low freezes the transfer
        mode = 0;
        wr(12'h010, 32'hDEAD_BEEF, 4'hF, st);
        @(negedge clk);
        while (!p_sel) @(negedge clk);
        mode = 1;
        @(posedge clk); #2;
        snap_sel = p_sel; snap_en = p_enable; snap_pend = write_pending; snap_mem = mem[4];
        repeat (8) @(negedge clk);
        chk("R5 p_sel held", {31'b0, p_sel}, {31'b0, snap_sel});
        chk("R5 p_enable held", {31'b0, p_enable}, {31'b0, snap_en});
        chk("R5 pending held", {31'b0, write_pending}, {31'b0, snap_pend});
        chk("R5 register held", mem[4], snap_mem);
        mode = 2;
        wait_drain();
        chk("R5 drained after enable", mem[4], 32'hDEAD_BEEF);

        // exact phases with slow_en held high, partial strobes
        @(posedge clk);
        wr(12'h014, 32'h1122_3344, 4'b0101, st);
        @(negedge clk);
        chk("R4 idle after accept", {30'b0, p_sel, p_enable}, 32'd0);
        @(negedge clk);
        chk("R4 setup phase", {30'b0, p_sel, p_enable}, 32'd2);
        @(negedge clk);
        chk("R4 access phase", {30'b0, p_sel, p_enable}, 32'd3);
        chk("R8 strobes forwarded", {28'b0, p_strb}, 32'h5);
        chk("R2 pending in access", {31'b0, write_pending}, 32'd1);
        @(negedge clk);
        chk("R2 pending low after access", {31'b0, write_pending}, 32'd0);
        chk("R8 masked lanes", mem[5], merge(32'h0505_0505, 32'h1122_3344, 4'b0101));
        wr(12'h018, 32'h7766_5544, 4'hF, st);
        chk("R1 accept with enable high", st, 0);

        // random mix
        mode = 0;
        for (int n = 0; n < 400; n++) begin
            logic [11:0] a;
            a = {6'b0, 4'($urandom % 16), 2'b00};
            if (($urandom % 2) == 0) begin
                logic [31:0] wd = $urandom;
                logic [3:0]  be = 4'($urandom);
                wr(a, wd, be, st);
            end else begin
                rd(a, d, st);
                chk("R7 random read", d, shadow[a[5:2]]);
            end
        end
        wait_drain();
        for (int i = 0; i < 16; i++) chk("R3 final register", mem[i], shadow[i]);
        finish_run();
    end
endmodule